// File: doc/BRIEF.md
# Serial Flash Quad-Enable Sequencer

This block runs by itself once reset is released. It talks to one serial NOR flash over a single-lane SPI master port, in mode 0 with the most significant bit first. Its goal is to leave the flash with its quad-enable status bit set, and then to tell the rest of the chip which quad read mode the fetch path may use.

It first reads the three-byte identification. The manufacturer byte selects the position of the quad-enable bit. The sequencer then waits until the flash is idle and reads the status. If the bit is already set, no write is issued. Otherwise it sends a write-enable command, then a write-status command carrying the old status with the bit added. It waits for the write to finish, reads the status again and checks the bit. Every busy-poll loop has an attempt limit. When the sequence ends, `done` rises and stays high until the next reset, together with the verdict, the identification and the selected read mode.

Top module: `qspi_qe_enable`

## Requirements
- R1: While reset is held and just after it, the chip select is high and the serial clock is low. `done` and `success` are 0, `read_mode` is 0 and `flash_id` is 0.
- R2: Every command uses SPI mode 0, with the clock idle low, data sampled on the rising edge and sent most significant bit first. Every command is a whole number of bytes. The chip select stays high for at least one full serial clock period between commands.
- R3: The first command is 0x9F followed by three read bytes. `flash_id` holds them with the first received byte in bits 7:0, the second in 15:8 and the third in 23:16.
- R4: The quad-enable position comes from `flash_id[7:0]`. For 0x9D and 0xC2 it is status bit 6. For any other value it is bit 9, which is bit 1 of the second status register. That register is read with opcode 0x35 and written as the second data byte of a two-byte 0x01 command.
- R5: Before any status is used, and before any write, opcode 0x05 is polled until bit 0 (write in progress) reads 0. Exactly one more 0x05 read then supplies the status.
- R6: If the quad-enable bit is already set, neither 0x06 nor 0x01 is sent.
- R7: If the bit is clear, 0x06 is sent, then 0x01 carrying the status read before, OR'd with the bit mask. The first data byte is status register 1 and the optional second byte is status register 2.
- R8: After the write, 0x05 is polled until idle, and then the status is read again. If the bit is still clear, `done` rises with `success` 0 and `read_mode` 0.
- R9: On success, `read_mode` is 2 (quad I/O). If `quad_out_sel` is 1, it is 1 (quad output) instead.
- R10: If POLL_MAX consecutive 0x05 reads all report busy, polling stops. `done` rises with `success` 0 and `read_mode` 0, and no write command follows.
- R11: Once `done` is 1, it stays 1. `success`, `read_mode` and `flash_id` hold, and no further command is issued until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| quad_out_sel | input | 1 | Selects quad-output read mode instead of quad I/O on success |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| done | output | 1 | Sequence finished (sticky) |
| success | output | 1 | Quad-enable bit confirmed set |
| flash_id | output | 24 | Identification bytes, first received byte lowest |
| read_mode | output | 2 | 0 single, 1 quad output, 2 quad I/O |

## Verification
The bench targets the bit already set, and a design that skipped that check would issue a needless write. It checks the manufacturer fallback to bit 9, where a design that only handled status register 1 would send a one-byte write and never set the bit. It covers a write the flash silently ignores, which a design without read-back would wrongly report as a success. It also checks a flash that stays busy forever, which would hang a design with no poll limit, and a busy period after the write, which a design that read back too early would misjudge. The bench counts every opcode the flash model sees and compares the written bytes, the poll counts and the identification ordering against values computed from the requirements.

// File: rtl/qe_pkg.sv
package qe_pkg;

    localparam logic [7:0] OP_READ_ID  = 8'h9F;
    localparam logic [7:0] OP_READ_SR1 = 8'h05;
    localparam logic [7:0] OP_READ_SR2 = 8'h35;
    localparam logic [7:0] OP_WR_EN    = 8'h06;
    localparam logic [7:0] OP_WR_SR    = 8'h01;

    localparam logic [1:0] RM_SINGLE = 2'd0;
    localparam logic [1:0] RM_QOUT   = 2'd1;
    localparam logic [1:0] RM_QIO    = 2'd2;

    typedef enum logic [3:0] {
        ST_GAP,
        ST_RDID,
        ST_POLL_A,
        ST_RDSR1,
        ST_RDSR2,
        ST_WREN,
        ST_WRSR,
        ST_POLL_B,
        ST_VER1,
        ST_VER2,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/qe_bit_lookup.sv
module qe_bit_lookup #(
    parameter int                      N_ENTRIES   = 2,
    parameter logic [N_ENTRIES*8-1:0]  MFR_LIST    = {8'hC2, 8'h9D},
    parameter logic [N_ENTRIES*4-1:0]  POS_LIST    = {4'd6, 4'd6},
    parameter logic [3:0]              DEFAULT_POS = 4'd9
) (
    input  logic [7:0] mfr,
    output logic [3:0] qe_pos
);

    logic [N_ENTRIES-1:0] hit;

    generate
        for (genvar g = 0; g < N_ENTRIES; g++) begin : g_match
            assign hit[g] = (mfr == MFR_LIST[g*8 +: 8]);
        end
    endgenerate

    // lowest table index wins when entries repeat
    always_comb begin
        qe_pos = DEFAULT_POS;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) qe_pos = POS_LIST[i*4 +: 4];
        end
    end

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx
);

    localparam int DIV_W = $clog2(HALF_DIV) + 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             run;
        logic             sclk;
        logic [DIV_W-1:0] div;
        logic [2:0]       bitc;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic             done;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.run) begin
            if (start) begin
                d.run  = 1'b1;
                d.sclk = 1'b0;
                d.div  = '0;
                d.bitc = '0;
                d.sh   = tx;
            end
        end else if (q.div == DIV_LAST) begin
            d.div = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
                d.rx   = {q.rx[6:0], miso};
            end else begin
                d.sclk = 1'b0;
                if (q.bitc == 3'd7) begin
                    d.run  = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bitc = q.bitc + 3'd1;
                    d.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk = q.sclk;
    assign mosi = q.sh[7];
    assign done = q.done;
    assign rx   = q.rx;

    // R2: data must be settled when the flash samples it
    a_r2_mosi_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    // R2: a byte ends with the clock back at its idle level
    a_r2_done_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sclk);

endmodule

// File: rtl/qspi_qe_enable.sv
module qspi_qe_enable #(
    parameter int HALF_DIV = 2,
    parameter int POLL_MAX = 16,
    parameter int GAP_CLKS = 2 * HALF_DIV
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        quad_out_sel,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    input  logic        spi_miso,
    output logic        done,
    output logic        success,
    output logic [23:0] flash_id,
    output logic [1:0]  read_mode
);
    import qe_pkg::*;

    localparam int GAP_W  = $clog2(GAP_CLKS) + 1;
    localparam int POLL_W = $clog2(POLL_MAX) + 1;
    localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(GAP_CLKS - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_MAX - 1);

    typedef struct packed {
        seq_state_e        state;
        seq_state_e        ret;
        logic              cs_n;
        logic [GAP_W-1:0]  gap;
        logic [2:0]        idx;
        logic              wait_b;
        logic [POLL_W-1:0] poll;
        logic [23:0]       id;
        logic [7:0]        sr_lo;
        logic [7:0]        sr_hi;
        logic              done;
        logic              ok;
        logic [1:0]        mode;
    } seq_t;

    seq_t q, d;

    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;
    logic [3:0] qe_pos;

    spi_byte_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .tx    (eng_tx),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (eng_done),
        .rx    (eng_rx)
    );

    qe_bit_lookup u_lookup (
        .mfr    (q.id[7:0]),
        .qe_pos (qe_pos)
    );

    logic        wide;
    logic [15:0] qe_mask;
    assign wide    = qe_pos[3];
    assign qe_mask = 16'd1 << qe_pos;

    logic [2:0] n_bytes;
    logic [7:0] opcode;

    always_comb begin
        n_bytes = 3'd2;
        opcode  = OP_READ_SR1;
        case (q.state)
            ST_RDID:  begin n_bytes = 3'd4; opcode = OP_READ_ID;  end
            ST_RDSR2: begin n_bytes = 3'd2; opcode = OP_READ_SR2; end
            ST_VER2:  begin n_bytes = 3'd2; opcode = OP_READ_SR2; end
            ST_WREN:  begin n_bytes = 3'd1; opcode = OP_WR_EN;    end
            ST_WRSR:  begin n_bytes = wide ? 3'd3 : 3'd2; opcode = OP_WR_SR; end
            default:  ;
        endcase
    end

    always_comb begin
        logic        go;
        logic        fin;
        logic        fin_ok;
        seq_state_e  nxt;
        logic        last;
        logic [15:0] st16;

        d         = q;
        go        = 1'b0;
        fin       = 1'b0;
        fin_ok    = 1'b0;
        nxt       = ST_GAP;
        st16      = '0;
        eng_start = 1'b0;
        eng_tx    = 8'h00;
        last      = (q.idx + 3'd1 == n_bytes);

        if (q.idx == 3'd0)                              eng_tx = opcode;
        else if (q.state == ST_WRSR && q.idx == 3'd1)   eng_tx = q.sr_lo | qe_mask[7:0];
        else if (q.state == ST_WRSR)                    eng_tx = q.sr_hi | qe_mask[15:8];

        case (q.state)
            ST_GAP: begin
                if (q.gap == '0) begin
                    d.state  = q.ret;
                    d.cs_n   = 1'b0;
                    d.idx    = '0;
                    d.wait_b = 1'b0;
                end else begin
                    d.gap = q.gap - 1'b1;
                end
            end
            ST_DONE: ;
            default: begin
                if (!q.wait_b && q.idx < n_bytes) begin
                    eng_start = 1'b1;
                    d.wait_b  = 1'b1;
                end else if (q.wait_b && eng_done) begin
                    d.wait_b = 1'b0;
                    d.idx    = q.idx + 3'd1;
                    if (q.state == ST_RDID) begin
                        case (q.idx)
                            3'd1:    d.id[7:0]   = eng_rx;
                            3'd2:    d.id[15:8]  = eng_rx;
                            default: d.id[23:16] = eng_rx;
                        endcase
                    end
                    if (last) begin
                        d.cs_n = 1'b1;
                        case (q.state)
                            ST_RDID: begin
                                go = 1'b1; nxt = ST_POLL_A; d.poll = '0;
                            end
                            ST_POLL_A, ST_POLL_B: begin
                                if (eng_rx[0]) begin
                                    if (q.poll == POLL_LAST) begin
                                        fin = 1'b1;
                                    end else begin
                                        d.poll = q.poll + 1'b1;
                                        go = 1'b1; nxt = q.state;
                                    end
                                end else begin
                                    go  = 1'b1;
                                    nxt = (q.state == ST_POLL_A) ? ST_RDSR1 : ST_VER1;
                                end
                            end
                            ST_RDSR1, ST_VER1, ST_RDSR2, ST_VER2: begin
                                if (q.state == ST_RDSR1 || q.state == ST_VER1) begin
                                    d.sr_lo = eng_rx;
                                    st16    = {q.sr_hi, eng_rx};
                                end else begin
                                    d.sr_hi = eng_rx;
                                    st16    = {eng_rx, q.sr_lo};
                                end
                                if (wide && (q.state == ST_RDSR1 || q.state == ST_VER1)) begin
                                    go  = 1'b1;
                                    nxt = (q.state == ST_RDSR1) ? ST_RDSR2 : ST_VER2;
                                end else if ((st16 & qe_mask) != '0) begin
                                    fin = 1'b1; fin_ok = 1'b1;
                                end else if (q.state == ST_RDSR1 || q.state == ST_RDSR2) begin
                                    go = 1'b1; nxt = ST_WREN;
                                end else begin
                                    fin = 1'b1;
                                end
                            end
                            ST_WREN: begin go = 1'b1; nxt = ST_WRSR; end
                            ST_WRSR: begin
                                go = 1'b1; nxt = ST_POLL_B; d.poll = '0;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        endcase

        if (go) begin
            d.state = ST_GAP;
            d.ret   = nxt;
            d.gap   = GAP_LOAD;
        end
        if (fin) begin
            d.state = ST_DONE;
            d.done  = 1'b1;
            d.ok    = fin_ok;
            d.mode  = fin_ok ? (quad_out_sel ? RM_QOUT : RM_QIO) : RM_SINGLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_GAP;
            q.ret   <= ST_RDID;
            q.cs_n  <= 1'b1;
            q.gap   <= GAP_LOAD;
        end else begin
            q <= d;
        end
    end

    assign spi_cs_n  = q.cs_n;
    assign done      = q.done;
    assign success   = q.ok;
    assign flash_id  = q.id;
    assign read_mode = q.mode;

    // R2: clock stays idle whenever the flash is deselected
    a_r2_clock_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);

    // R2: select edges only occur with the clock low
    a_r2_select_edge_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !spi_sclk);

    // R11: completion is sticky and the results hold
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done && $stable(flash_id) && $stable(read_mode) && $stable(success));

    // R11: no traffic after completion
    a_r11_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> spi_cs_n);

    // R8: a verdict only exists together with completion
    a_r8_success_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        success |-> done);

    // R9: a quad mode is granted only on success
    a_r9_mode_needs_success: assert property (@(posedge clk) disable iff (!rst_n)
        (read_mode != RM_SINGLE) |-> success);

    // R10: poll attempts never pass the limit
    a_r10_poll_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        q.poll <= POLL_LAST);

endmodule

// File: tb/qspi_qe_enable_test.sv
module qspi_qe_enable_test;

    localparam int HALF_DIV = 2;
    localparam int POLL_MAX = 16;
    localparam int MIN_GAP  = 2 * HALF_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        quad_out_sel = 1'b0;
    logic        spi_cs_n, spi_sclk, spi_mosi;
    logic        spi_miso = 1'b0;
    logic        done, success;
    logic [23:0] flash_id;
    logic [1:0]  read_mode;

    always #2 clk = ~clk;

    qspi_qe_enable #(.HALF_DIV(HALF_DIV), .POLL_MAX(POLL_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .quad_out_sel(quad_out_sel),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .done(done), .success(success),
        .flash_id(flash_id), .read_mode(read_mode)
    );

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- flash model ----------------
    logic [7:0] f_id [3];
    logic [7:0] f_sr1, f_sr2;
    int   f_busy, f_busy_after;
    bit   f_ignore;
    int   n9f, n05_pre, n05_post, n06, n01, n35, early, order_bad, partial, nw, txn;
    bit   wrote;
    logic [7:0] wbytes [2];
    logic [7:0] m_op, m_in, m_out;
    int   m_bit, m_bytes;

    function automatic logic [7:0] resp(input logic [7:0] op, input int i);
        case (op)
            8'h9F:   return (i < 3) ? f_id[i] : 8'h00;
            8'h05:   return {f_sr1[7:1], (f_busy > 0)};
            8'h35:   return f_sr2;
            default: return 8'h00;
        endcase
    endfunction

    always @(negedge spi_cs_n) begin
        m_bit = 0; m_bytes = 0; m_out = 8'h00; m_op = 8'h00;
    end

    always @(posedge spi_sclk) if (!spi_cs_n) begin
        m_in = {m_in[6:0], spi_mosi};
        m_bit++;
        if (m_bit == 8) begin
            m_bit = 0;
            if (m_bytes == 0) m_op = m_in;
            else if (m_op == 8'h01 && m_bytes <= 2) wbytes[m_bytes-1] = m_in;
            m_bytes++;
            m_out = resp(m_op, m_bytes - 1);
        end
    end

    always @(negedge spi_sclk) if (!spi_cs_n) begin
        spi_miso = m_out[7];
        m_out = {m_out[6:0], 1'b0};
    end

    always @(posedge spi_cs_n) if (rst_n) begin
        txn++;
        if (m_bit != 0) partial++;
        case (m_op)
            8'h9F: n9f++;
            8'h05: begin
                if (wrote) n05_post++; else n05_pre++;
                if (f_busy > 0) f_busy--;
            end
            8'h35: begin n35++; if (f_busy > 0) early++; end
            8'h06: begin n06++; if (f_busy > 0) early++; f_sr1[1] = 1'b1; end
            8'h01: begin
                n01++;
                nw = m_bytes - 1;
                if (f_busy > 0) early++;
                if (!f_sr1[1]) order_bad++;
                if (!f_ignore) begin
                    f_sr1 = wbytes[0] & 8'hFC;
                    if (nw >= 2) f_sr2 = wbytes[1];
                end
                f_sr1[1] = 1'b0;
                f_busy = f_busy_after;
                wrote = 1'b1;
            end
            default: ;
        endcase
    end

    // chip-select high time between commands
    int hi_cnt = 0;
    int gap_bad = 0;
    bit seen_low = 0;
    always @(negedge clk) begin
        if (spi_cs_n) hi_cnt++;
        else begin
            if (seen_low && hi_cnt > 0 && hi_cnt < MIN_GAP) gap_bad++;
            if (hi_cnt > 0 || !seen_low) seen_low = 1;
            hi_cnt = 0;
        end
        if (!rst_n) begin seen_low = 0; hi_cnt = 0; end
    end

    // global watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    function automatic int qe_pos_of(input logic [7:0] mfr);
        return (mfr == 8'h9D || mfr == 8'hC2) ? 6 : 9;
    endfunction

    task automatic run_case(input logic [7:0] i0, i1, i2, input logic [7:0] sr1, sr2,
                            input int busy0, busy_after, input bit ign, input bit sel);
        int pos, tmo, waited, txn_done;
        bit wide, already, exp_ok;
        logic [15:0] st16;
        logic [23:0] id_done;

        rst_n = 1'b0;
        quad_out_sel = sel;
        f_id[0] = i0; f_id[1] = i1; f_id[2] = i2;
        f_sr1 = sr1; f_sr2 = sr2; f_busy = busy0; f_busy_after = busy_after; f_ignore = ign;
        n9f = 0; n05_pre = 0; n05_post = 0; n06 = 0; n01 = 0; n35 = 0;
        early = 0; order_bad = 0; partial = 0; nw = 0; txn = 0; wrote = 0; gap_bad = 0;
        wbytes[0] = 8'h00; wbytes[1] = 8'h00;
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", spi_cs_n, 1);
        chk("R1 sclk in reset", spi_sclk, 0);
        chk("R1 done/success in reset", {done, success}, 0);
        chk("R1 mode/id in reset", {read_mode, flash_id}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {spi_cs_n, spi_sclk, done}, 3'b100);

        waited = 0;
        while (!done && waited < 60000) begin @(negedge clk); waited++; end
        chk("R11 sequence completes", done, 1);

        pos     = qe_pos_of(i0);
        wide    = (pos >= 8);
        st16    = {sr2, sr1[7:1], 1'b0};
        already = st16[pos];
        tmo     = (busy0 >= POLL_MAX);

        chk("R3 id ordering", flash_id, {i2, i1, i0});
        chk("R3 one id read", n9f, 1);
        chk("R2 whole bytes", partial, 0);
        chk("R2 select gap", gap_bad, 0);
        chk("R5 no access while busy", early, 0);
        chk("R7 enable before write", order_bad, 0);

        if (tmo) begin
            chk("R10 polls until limit", n05_pre, POLL_MAX);
            chk("R10 no write on timeout", n06 + n01, 0);
            chk("R10 verdict", {success, read_mode}, 0);
        end else begin
            chk("R5 poll then read", n05_pre, busy0 + 2);
            chk("R4 second register reads", n35,
                wide ? (already ? 1 : (busy_after >= POLL_MAX ? 1 : 2)) : 0);
            if (already) begin
                chk("R6 no enable/write", n06 + n01, 0);
                exp_ok = 1;
            end else begin
                chk("R7 one enable", n06, 1);
                chk("R7 one write", n01, 1);
                chk("R4 write length", nw, wide ? 2 : 1);
                chk("R7 first data byte", wbytes[0],
                    wide ? st16[7:0] : (st16[7:0] | (8'd1 << pos)));
                if (wide) chk("R7 second data byte", wbytes[1], sr2 | (8'd1 << (pos - 8)));
                if (busy_after >= POLL_MAX) begin
                    chk("R10 post-write timeout polls", n05_post, POLL_MAX);
                    exp_ok = 0;
                end else begin
                    chk("R8 poll then reread", n05_post, busy_after + 2);
                    exp_ok = !ign;
                end
            end
            chk("R8 success", success, exp_ok);
            chk("R9 read mode", read_mode, exp_ok ? (sel ? 1 : 2) : 0);
        end

        txn_done = txn;
        id_done  = flash_id;
        repeat (40) @(negedge clk);
        chk("R11 done holds", done, 1);
        chk("R11 id holds", flash_id, id_done);
        chk("R11 no further commands", txn, txn_done);
    endtask

    initial begin
        logic [7:0] mf;
        int sel_pick;
        void'($urandom(32'h5EED_1234));
        // directed corners
        run_case(8'h9D, 8'h70, 8'h15, 8'h02, 8'h00, 0, 1, 0, 0); // R7 write 0x42, reads 0x40
        run_case(8'h9D, 8'h70, 8'h15, 8'h40, 8'h00, 0, 0, 0, 0); // R6 already set
        run_case(8'hC2, 8'h20, 8'h16, 8'h00, 8'h00, 2, 3, 0, 1); // R9 quad output, busy both loops
        run_case(8'h55, 8'h40, 8'h17, 8'h0C, 8'h30, 1, 1, 0, 0); // R4 fallback bit 9
        run_case(8'hEF, 8'h40, 8'h18, 8'h00, 8'h02, 0, 0, 0, 0); // R4/R6 bit 9 already set
        run_case(8'h9D, 8'h70, 8'h15, 8'h00, 8'h00, 0, 2, 1, 0); // R8 write ignored
        run_case(8'h9D, 8'h70, 8'h15, 8'h00, 8'h00, 1000, 0, 0, 0); // R10 stuck busy
        run_case(8'hC2, 8'h20, 8'h16, 8'h00, 8'h00, 0, 1000, 0, 0); // R10 stuck after write
        // constrained random
        for (int k = 0; k < 10; k++) begin
            sel_pick = $urandom_range(0, 3);
            mf = (sel_pick == 0) ? 8'h9D : (sel_pick == 1) ? 8'hC2 : 8'($urandom);
            run_case(mf, 8'($urandom), 8'($urandom), 8'($urandom) & 8'hFE, 8'($urandom),
                     $urandom_range(0, 5), $urandom_range(0, 5),
                     ($urandom_range(0, 4) == 0), $urandom_range(0, 1) == 1);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule